// File: doc/BRIEF.md
# Key-protected independent watchdog

This block is a watchdog timer split across two clocks. A bus-side register file, running on the system clock, accepts 16-bit key words and configuration writes. A down-counter, running on a separate slow clock that keeps ticking when the system clock is unreliable, counts out the timeout. When it reaches zero it raises a reset request. Software arms the watchdog once and must then keep refreshing it. The divide ratio and reload value can be changed only after an unlock key has been written.

Configuration values cross into the slow domain through a request/acknowledge handshake, one per register. The status register shows which handshakes are still in flight. The slow-domain counter uses the new settings only when it next reloads, either on a refresh, on a start, or after an expiry. A full timeout lasts (reload + 1) × divide slow-clock cycles. The divide is 4 << code, and codes above 6 act as 6.

Top module: `kwdg_top`

## Requirements
- R1: After reset the prescaler register (offset 0x04) reads 0, the reload register (offset 0x08) reads 0xFFF, the status register (offset 0x0C) reads 0, and the key (0x00) and window (0x10) offsets read 0.
- R2: Writes to offsets 0x04 and 0x08 take effect only while unlocked. Key 0x5555 at offset 0x00 unlocks. Any other key word, including 0x0000 and undefined values, locks again. A locked write leaves the readback unchanged.
- R3: An accepted prescaler write sets status bit 0 and an accepted reload write sets status bit 1, readable on the next bus cycle. Each bit clears once the slow domain has captured the value. A write to a register whose bit is still set is ignored.
- R4: Prescaler code c (3 bits) divides the slow clock by 4 << c for c = 0..6. Code 7 divides by 256.
- R5: Once running, consecutive reset-request pulses are exactly (reload + 1) × divide slow-clock cycles apart.
- R6: Before key 0xCCCC has been written, the reset request never rises.
- R7: Key 0xAAAA while running reloads the counter, so refreshes issued faster than the timeout prevent any reset request.
- R8: Once started, no key word or register write stops the watchdog. Only the block reset returns it to idle.
- R9: On expiry the reset request is high for exactly one slow-clock cycle, and counting then restarts from the reload value.
- R10: New prescaler or reload values reach the counter only at its next load (start, refresh or expiry). The interval already in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | System (register) clock |
| clk_lp | input | 1 | Low-speed counter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data (key word or register value) |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| rst_req | output | 1 | Reset request pulse, slow-clock domain |

## Verification
A lost or duplicated handshake toggle shows up within a few bus cycles as a status bit that never clears or never sets. It can also show as a readback that accepts a write it should have refused. A wrong divide or reload in the slow domain changes the spacing of reset-request pulses. The bench therefore measures that spacing in slow-clock cycles between two consecutive pulses, which removes the synchronizer latency from the result. Stale staging in the counter shows only one interval later, so every reconfiguration is followed by a measured interval after the boundary.

// File: rtl/kwdg_pkg.sv
package kwdg_pkg;

    localparam int KEY_W   = 16;
    localparam int ADDR_W  = 5;

    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

    localparam int OFS_KEY  = 'h00;
    localparam int OFS_PSC  = 'h04;
    localparam int OFS_RLD  = 'h08;
    localparam int OFS_STAT = 'h0C;

    // smallest divide is 1 << DIV_MIN_LOG, largest code honoured is PSC_TOP
    localparam int DIV_MIN_LOG = 2;
    localparam int PSC_TOP     = 6;

endpackage

// File: rtl/kwdg_sync.sv
// Multi-stage synchronizer chain, STAGES must be at least 2.
module kwdg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-W-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/kwdg_regs.sv
// Bus-domain register file: key decode, lock, shadow registers, handshake sources.
module kwdg_regs
    import kwdg_pkg::*;
#(
    parameter int PSC_W = 3,
    parameter int RLD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  bus_wdata,
    input  logic              psc_ack_s,
    input  logic              rld_ack_s,
    output logic [KEY_W-1:0]  bus_rdata,
    output logic [PSC_W-1:0]  psc_val,
    output logic [RLD_W-1:0]  rld_val,
    output logic              psc_req,
    output logic              rld_req,
    output logic              start_tgl,
    output logic              refresh_tgl,
    output logic              unlocked,
    output logic              psc_busy,
    output logic              rld_busy
);
    typedef struct packed {
        logic             unlocked;
        logic [PSC_W-1:0] psc;
        logic [RLD_W-1:0] rld;
        logic             psc_req;
        logic             rld_req;
        logic             start_tgl;
        logic             refresh_tgl;
    } regs_t;

    regs_t st_d, st_q;
    logic  key_wr, psc_wr, rld_wr;

    always_comb begin
        psc_busy = st_q.psc_req != psc_ack_s;
        rld_busy = st_q.rld_req != rld_ack_s;
        key_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));
        psc_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_PSC)) && st_q.unlocked && !psc_busy;
        rld_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_RLD)) && st_q.unlocked && !rld_busy;

        st_d = st_q;
        if (key_wr) begin
            st_d.unlocked = (bus_wdata == KEY_UNLOCK);
            if (bus_wdata == KEY_START)   st_d.start_tgl   = ~st_q.start_tgl;
            if (bus_wdata == KEY_REFRESH) st_d.refresh_tgl = ~st_q.refresh_tgl;
        end
        if (psc_wr) begin
            st_d.psc     = bus_wdata[PSC_W-1:0];
            st_d.psc_req = ~st_q.psc_req;
        end
        if (rld_wr) begin
            st_d.rld     = bus_wdata[RLD_W-1:0];
            st_d.rld_req = ~st_q.rld_req;
        end

        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_PSC):  bus_rdata[PSC_W-1:0] = st_q.psc;
            ADDR_W'(OFS_RLD):  bus_rdata[RLD_W-1:0] = st_q.rld;
            ADDR_W'(OFS_STAT): bus_rdata[1:0]       = {rld_busy, psc_busy};
            default:           bus_rdata            = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rld <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign psc_val     = st_q.psc;
    assign rld_val     = st_q.rld;
    assign psc_req     = st_q.psc_req;
    assign rld_req     = st_q.rld_req;
    assign start_tgl   = st_q.start_tgl;
    assign refresh_tgl = st_q.refresh_tgl;
    assign unlocked    = st_q.unlocked;
endmodule

// File: rtl/kwdg_counter.sv
// Slow-domain side: handshake capture, prescaler divider, down-counter, expiry pulse.
module kwdg_counter #(
    parameter int PSC_W       = 3,
    parameter int RLD_W       = 12,
    parameter int DIV_MIN_LOG = 2,
    parameter int PSC_TOP     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_s,
    input  logic             refresh_s,
    input  logic             psc_req_s,
    input  logic             rld_req_s,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [RLD_W-1:0] rld_in,
    output logic             psc_ack,
    output logic             rld_ack,
    output logic             running,
    output logic             rst_req
);
    localparam int DIV_W = DIV_MIN_LOG + PSC_TOP;

    typedef struct packed {
        logic             start_seen;
        logic             refresh_seen;
        logic             psc_ack;
        logic             rld_ack;
        logic             running;
        logic             req;
        logic [PSC_W-1:0] psc_stage;
        logic [PSC_W-1:0] psc_act;
        logic [RLD_W-1:0] rld_stage;
        logic [RLD_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       start_ev, refresh_ev, tick, load;

    function automatic logic [DIV_W-1:0] div_last(input logic [PSC_W-1:0] code);
        int sel;
        sel = (int'(code) > PSC_TOP) ? PSC_TOP : int'(code);
        return DIV_W'((1 << (DIV_MIN_LOG + sel)) - 1);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;

        if (psc_req_s != st_q.psc_ack) begin
            st_d.psc_stage = psc_in;
            st_d.psc_ack   = psc_req_s;
        end
        if (rld_req_s != st_q.rld_ack) begin
            st_d.rld_stage = rld_in;
            st_d.rld_ack   = rld_req_s;
        end

        start_ev          = start_s != st_q.start_seen;
        refresh_ev        = refresh_s != st_q.refresh_seen;
        st_d.start_seen   = start_s;
        st_d.refresh_seen = refresh_s;

        tick = st_q.div == div_last(st_q.psc_act);
        load = 1'b0;

        if (start_ev || (refresh_ev && st_q.running)) begin
            st_d.running = 1'b1;
            load         = 1'b1;
        end else if (st_q.running) begin
            if (tick) begin
                st_d.div = '0;
                if (st_q.cnt == '0) begin
                    st_d.req = 1'b1;
                    load     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end

        if (load) begin
            st_d.cnt     = st_q.rld_stage;
            st_d.psc_act = st_q.psc_stage;
            st_d.div     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.rld_stage <= '1;
            st_q.cnt       <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign psc_ack = st_q.psc_ack;
    assign rld_ack = st_q.rld_ack;
    assign running = st_q.running;
    assign rst_req = st_q.req;
endmodule

// File: rtl/kwdg_top.sv
module kwdg_top
    import kwdg_pkg::*;
#(
    parameter int PSC_W       = 3,
    parameter int RLD_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_bus,
    input  logic              clk_lp,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  bus_wdata,
    output logic [KEY_W-1:0]  bus_rdata,
    output logic              rst_req
);
    localparam int TO_LP_W  = 4;
    localparam int TO_BUS_W = 2;

    logic [PSC_W-1:0] psc_val_w;
    logic [RLD_W-1:0] rld_val_w;
    logic psc_req_w, rld_req_w, start_w, refresh_w;
    logic unlocked_w, psc_busy_w, rld_busy_w;
    logic psc_ack_w, rld_ack_w, running_w;
    logic psc_ack_s, rld_ack_s;
    logic start_s, refresh_s, psc_req_s, rld_req_s;

    kwdg_regs #(.PSC_W(PSC_W), .RLD_W(RLD_W)) regs_i (
        .clk        (clk_bus),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .psc_ack_s  (psc_ack_s),
        .rld_ack_s  (rld_ack_s),
        .bus_rdata  (bus_rdata),
        .psc_val    (psc_val_w),
        .rld_val    (rld_val_w),
        .psc_req    (psc_req_w),
        .rld_req    (rld_req_w),
        .start_tgl  (start_w),
        .refresh_tgl(refresh_w),
        .unlocked   (unlocked_w),
        .psc_busy   (psc_busy_w),
        .rld_busy   (rld_busy_w)
    );

    kwdg_sync #(.W(TO_LP_W), .STAGES(SYNC_STAGES)) to_lp_i (
        .clk  (clk_lp),
        .rst_n(rst_n),
        .d    ({start_w, refresh_w, psc_req_w, rld_req_w}),
        .q    ({start_s, refresh_s, psc_req_s, rld_req_s})
    );

    kwdg_sync #(.W(TO_BUS_W), .STAGES(SYNC_STAGES)) to_bus_i (
        .clk  (clk_bus),
        .rst_n(rst_n),
        .d    ({psc_ack_w, rld_ack_w}),
        .q    ({psc_ack_s, rld_ack_s})
    );

    kwdg_counter #(
        .PSC_W      (PSC_W),
        .RLD_W      (RLD_W),
        .DIV_MIN_LOG(DIV_MIN_LOG),
        .PSC_TOP    (PSC_TOP)
    ) counter_i (
        .clk      (clk_lp),
        .rst_n    (rst_n),
        .start_s  (start_s),
        .refresh_s(refresh_s),
        .psc_req_s(psc_req_s),
        .rld_req_s(rld_req_s),
        .psc_in   (psc_val_w),
        .rld_in   (rld_val_w),
        .psc_ack  (psc_ack_w),
        .rld_ack  (rld_ack_w),
        .running  (running_w),
        .rst_req  (rst_req)
    );
endmodule

// File: rtl/kwdg_checker.sv
module kwdg_checker
    import kwdg_pkg::*;
#(
    parameter int RLD_W = 12
) (
    input logic              clk_bus,
    input logic              clk_lp,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              unlocked,
    input logic              rld_busy,
    input logic [RLD_W-1:0]  rld_val,
    input logic              running,
    input logic              rst_req
);
    logic rld_write;
    assign rld_write = bus_wr && (bus_addr == ADDR_W'(OFS_RLD));

    p_locked_hold_r2: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (rld_write && !unlocked) |=> $stable(rld_val));

    p_busy_rise_r3: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (rld_write && unlocked && !rld_busy) |=> rld_busy);

    p_busy_hold_r3: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (rld_write && rld_busy) |=> $stable(rld_val));

    p_idle_quiet_r6: assert property (@(posedge clk_lp) disable iff (!rst_n)
        !running |-> !rst_req);

    p_sticky_run_r8: assert property (@(posedge clk_lp) disable iff (!rst_n)
        running |=> running);

    p_single_pulse_r9: assert property (@(posedge clk_lp) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

bind kwdg_top kwdg_checker #(.RLD_W(RLD_W)) chk_i (
    .clk_bus (clk_bus),
    .clk_lp  (clk_lp),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .unlocked(unlocked_w),
    .rld_busy(rld_busy_w),
    .rld_val (rld_val_w),
    .running (running_w),
    .rst_req (rst_req)
);

// File: tb/kwdg_top_tb_top.sv
module kwdg_top_tb_top;
    localparam logic [4:0] A_KEY = 5'h00, A_PSC = 5'h04, A_RLD = 5'h08,
                           A_STAT = 5'h0C, A_WIN = 5'h10;

    logic        clk_bus = 1'b0, clk_lp = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int vectors = 0, fails = 0;
    int lp_cyc = 0, pulse_cnt = 0, last_pulse = 0;
    bit done = 1'b0;

    always #10 clk_bus = ~clk_bus;
    always #65 clk_lp  = ~clk_lp;

    kwdg_top dut_i (
        .clk_bus(clk_bus), .clk_lp(clk_lp), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always @(negedge clk_lp) begin
        lp_cyc <= lp_cyc + 1;
        if (rst_req) begin
            pulse_cnt  <= pulse_cnt + 1;
            last_pulse <= lp_cyc;
        end
    end

    function automatic int exp_period(input int code, input int rld);
        int c;
        c = (code > 6) ? 6 : code;
        return (rld + 1) * (4 << c);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk_bus);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_bus);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        @(negedge clk_bus);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wait_idle();
        int v;
        for (int i = 0; i < 200; i++) begin
            rd(A_STAT, v);
            if (v == 0) break;
        end
    endtask

    task automatic configure(input int code, input int rld);
        wr(A_KEY, 16'h5555);
        wr(A_PSC, 16'(code));
        wait_idle();
        wr(A_RLD, 16'(rld));
        wait_idle();
        wr(A_KEY, 16'h0000);
    endtask

    task automatic wait_pulse();
        int n0;
        n0 = pulse_cnt;
        while (pulse_cnt == n0) @(negedge clk_lp);
        @(negedge clk_lp);
    endtask

    // interval between the next two pulses after the current boundary
    task automatic measure(output int per);
        int t0;
        wait_pulse();
        t0 = last_pulse;
        wait_pulse();
        per = last_pulse - t0;
    endtask

    initial begin
        repeat (190000) @(posedge clk_bus);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int v, per, n0, t0;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk_bus);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_bus);

        // R1 reset readback
        rd(A_PSC, v);  chk("R1 prescaler", v, 0);
        rd(A_RLD, v);  chk("R1 reload", v, 'hFFF);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_KEY, v);  chk("R1 key", v, 0);
        rd(A_WIN, v);  chk("R1 window", v, 0);

        // R2 locked write ignored
        wr(A_RLD, 16'd5);
        rd(A_RLD, v);  chk("R2 locked reload", v, 'hFFF);
        rd(A_STAT, v); chk("R2 locked status", v, 0);
        // R2 undefined key relocks
        wr(A_KEY, 16'h5555);
        wr(A_KEY, 16'h1234);
        wr(A_RLD, 16'd5);
        rd(A_RLD, v);  chk("R2 relock by junk key", v, 'hFFF);

        // R3 busy flag and write while busy
        wr(A_KEY, 16'h5555);
        wr(A_RLD, 16'd3);
        rd(A_STAT, v); chk("R3 reload busy bit1", v, 2);
        wr(A_RLD, 16'd9);
        rd(A_RLD, v);  chk("R3 write while busy ignored", v, 3);
        wait_idle();
        rd(A_STAT, v); chk("R3 busy cleared", v, 0);
        wr(A_PSC, 16'd0);
        rd(A_STAT, v); chk("R3 prescaler busy bit0", v, 1);
        wait_idle();
        wr(A_KEY, 16'h0000);
        wr(A_RLD, 16'd7);
        rd(A_RLD, v);  chk("R2 lock by 0x0000", v, 3);

        // R6 no request before start
        repeat (300) @(negedge clk_lp);
        chk("R6 no pulse before start", pulse_cnt, 0);

        // R5 / R4 start and period
        wr(A_KEY, 16'hCCCC);
        measure(per); chk("R5 period rld3 div4", per, exp_period(0, 3));

        // R8 cannot be stopped
        wr(A_KEY, 16'h0000);
        wr(A_KEY, 16'h1234);
        wr(A_KEY, 16'h5555);
        wr(A_KEY, 16'h0000);
        measure(per); chk("R8 still running", per, exp_period(0, 3));

        // R10 mid-interval change: old interval keeps length
        configure(0, 7);
        measure(per); chk("R10 new reload applied", per, exp_period(0, 7));
        wait_pulse();
        t0 = last_pulse;
        configure(0, 1);
        wait_pulse();
        chk("R10 interval in progress unchanged", last_pulse - t0, exp_period(0, 7));
        t0 = last_pulse;
        wait_pulse();
        chk("R10 next interval new", last_pulse - t0, exp_period(0, 1));

        // R4 prescaler codes including 7
        configure(1, 7);
        measure(per); chk("R4 code1 div8", per, exp_period(1, 7));
        configure(7, 0);
        measure(per); chk("R4 code7 div256", per, 256);
        configure(6, 0);
        measure(per); chk("R4 code6 div256", per, 256);

        // R7 refresh holds off expiry
        configure(2, 7);
        wait_pulse();
        n0 = pulse_cnt;
        for (int i = 0; i < 10; i++) begin
            repeat (40) @(negedge clk_lp);
            wr(A_KEY, 16'hAAAA);
        end
        chk("R7 no pulse while refreshed", pulse_cnt, n0);
        repeat (200) @(negedge clk_lp);
        chk("R7 pulse after refresh stops", int'(pulse_cnt > n0), 1);

        // R9 pulse width one cycle, then counting resumes (period above)
        wait_pulse();
        chk("R9 single-cycle pulse", int'(rst_req), 0);

        // R5 random configurations
        for (int i = 0; i < 6; i++) begin
            int code, rld;
            code = int'($urandom % 4);
            rld  = 2 + int'($urandom % 10);
            configure(code, rld);
            measure(per);
            chk("R5 random period", per, exp_period(code, rld));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule